// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block runs a general-purpose I/O port of eight pins, and the pin count is a parameter. Software reaches it through a small register bus. The bus holds a direction byte, an output byte and a special-function enable byte, and it has a read-only view of the pin levels. Every register can be accessed as a whole byte, or one bit at a time by setting `bus_bit_en` and giving a bit index.

From these settings the block produces three registered controls per pin: output enable, output value and weak-pullup enable. On a pin configured as an input, the output byte takes on a second role and switches that pin's pullup on or off. An on-chip peripheral can take over a pin through its special-function enable bit, and then the register settings have no effect on that pin. The pins selected by `SFEN_RESET` (the debug-interface pins) have this takeover active from reset. Alternate-function logic receives the synchronized pin levels on `alt_tap`, and these taps never change how a pin is driven.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While `rst` is high, and until the first write, the direction and output registers read 0. The special-function enable register reads `SFEN_RESET` (default 8'hF0). After reset, the pads of pins without an override are tri-stated with the pullup off.
- R2: A byte write at offset 0 (direction), 1 (output) or 3 (special-function enable) stores `bus_wdata`. A read at the same offset returns that byte on `bus_rdata` one clock after the address is presented.
- R3: With `bus_bit_en` high, a write changes only the bit indexed by `bus_bit_sel`, setting it to `bus_wdata[0]`. A read returns that bit in bit 0, with all other bits 0.
- R4: A pin with direction 0 and output 0 has `pad_oe`=0, `pad_out`=0 and `pad_pu`=0.
- R5: A pin with direction 0 and output 1 has `pad_oe`=0 and `pad_pu`=1.
- R6: A pin with direction 1 has `pad_oe`=1, `pad_out` equal to its output bit, and `pad_pu`=0.
- R7: Offset 2 returns the synchronized pin levels whatever the direction settings are. Writes to offset 2 change no register.
- R8: A pin whose special-function enable bit is 1 takes `pad_oe` from `sf_oe_in`. Its `pad_out` is `sf_oe_in & sf_out_in`, its `pad_pu` is 0, and its direction and output bits are ignored.
- R9: `alt_tap` equals `pad_in` delayed by two clocks (two-flop synchronizer). The drive settings have no effect on it.
- R10: Open-drain use: with the output bit at 0, setting the direction bit drives the pin low (oe=1, out=0). Clearing the direction bit releases the pin (oe=0, pullup off).
- R11: Pad controls are registered. They change on the clock edge after the edge that writes a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Register offset (0 dir, 1 out, 2 pin levels, 3 sf enable) |
| bus_bit_en | input | 1 | Single-bit access select |
| bus_bit_sel | input | 3 | Bit index for single-bit access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Raw pin levels |
| pad_oe | output | 8 | Per-pin driver enable |
| pad_out | output | 8 | Per-pin driven value |
| pad_pu | output | 8 | Per-pin weak pullup enable |
| sf_oe_in | input | 8 | Special-function driver enable |
| sf_out_in | input | 8 | Special-function output value |
| alt_tap | output | 8 | Synchronized pin levels for alternate functions |

## Verification
Two things can fall in the same cycle. One is an override from a peripheral on one pin. The other is ordinary register-controlled drive, or a pullup, on the neighbouring pins. The bench provokes this with mixed table vectors: some pins are taken over, some are outputs and some are pulled-up inputs. It then compares all three pad bytes against values worked out per pin. A second coincidence is a write to the read-only pin register in a cycle where direction is set. The bench judges this by reading back the pin levels and the direction byte, and both must stay unchanged.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_DIR  = 2'd0,
    REG_OUT  = 2'd1,
    REG_PINS = 2'd2,
    REG_SFEN = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] synced
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      meta_q[i] <= raw[i];
      sync_q[i] <= meta_q[i];
    end
  end

  assign synced = sync_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int              WIDTH      = 8,
  parameter logic [WIDTH-1:0] SFEN_RESET = '0,
  localparam int             SEL_W      = $clog2(WIDTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bit_en,
  input  logic [SEL_W-1:0]  bit_sel,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  pins,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  out_q,
  output logic [WIDTH-1:0]  sfen_q,
  output logic [WIDTH-1:0]  rdata
);
  logic [WIDTH-1:0] cur;
  logic [WIDTH-1:0] nxt;
  logic [WIDTH-1:0] rd_sel;

  always_comb begin
    case (gpio_reg_e'(addr))
      REG_DIR:  cur = dir_q;
      REG_OUT:  cur = out_q;
      REG_PINS: cur = pins;
      default:  cur = sfen_q;
    endcase
  end

  always_comb begin
    nxt = cur;
    if (bit_en) nxt[bit_sel] = wdata[0];
    else        nxt = wdata;
  end

  always_comb begin
    rd_sel = '0;
    if (bit_en) rd_sel[0] = cur[bit_sel];
    else        rd_sel = cur;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      out_q  <= '0;
      sfen_q <= SFEN_RESET;
      rdata  <= '0;
    end else begin
      rdata <= rd_sel;
      if (we) begin
        case (gpio_reg_e'(addr))
          REG_DIR:  dir_q  <= nxt;
          REG_OUT:  out_q  <= nxt;
          REG_SFEN: sfen_q <= nxt;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] out,
  input  logic [WIDTH-1:0] sfen,
  input  logic [WIDTH-1:0] sf_oe,
  input  logic [WIDTH-1:0] sf_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_pu
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        pad_oe[i]  <= 1'b0;
        pad_out[i] <= 1'b0;
        pad_pu[i]  <= 1'b0;
      end else if (sfen[i]) begin
        pad_oe[i]  <= sf_oe[i];
        pad_out[i] <= sf_oe[i] & sf_out[i];
        pad_pu[i]  <= 1'b0;
      end else begin
        pad_oe[i]  <= dir[i];
        pad_out[i] <= dir[i] & out[i];
        pad_pu[i]  <= ~dir[i] & out[i];
      end
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int               WIDTH      = 8,
  parameter logic [WIDTH-1:0] SFEN_RESET = 8'hF0,
  localparam int              SEL_W      = $clog2(WIDTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_bit_en,
  input  logic [SEL_W-1:0]  bus_bit_sel,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_pu,
  input  logic [WIDTH-1:0]  sf_oe_in,
  input  logic [WIDTH-1:0]  sf_out_in,
  output logic [WIDTH-1:0]  alt_tap
);
  logic [WIDTH-1:0] pins_sync;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] out_q;
  logic [WIDTH-1:0] sfen_q;

  gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
    .clk    (clk),
    .raw    (pad_in),
    .synced (pins_sync)
  );

  gpio_regs #(.WIDTH(WIDTH), .SFEN_RESET(SFEN_RESET)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (bus_we),
    .addr    (bus_addr),
    .bit_en  (bus_bit_en),
    .bit_sel (bus_bit_sel),
    .wdata   (bus_wdata),
    .pins    (pins_sync),
    .dir_q   (dir_q),
    .out_q   (out_q),
    .sfen_q  (sfen_q),
    .rdata   (bus_rdata)
  );

  gpio_pad_mux #(.WIDTH(WIDTH)) u_pad (
    .clk     (clk),
    .rst     (rst),
    .dir     (dir_q),
    .out     (out_q),
    .sfen    (sfen_q),
    .sf_oe   (sf_oe_in),
    .sf_out  (sf_out_in),
    .pad_oe  (pad_oe),
    .pad_out (pad_out),
    .pad_pu  (pad_pu)
  );

  assign alt_tap = pins_sync;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int               WIDTH      = 8,
  parameter logic [WIDTH-1:0] SFEN_RESET = 8'hF0
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WIDTH-1:0]  pad_in,
  input logic [WIDTH-1:0]  pad_oe,
  input logic [WIDTH-1:0]  pad_pu,
  input logic [WIDTH-1:0]  sf_oe_in,
  input logic [WIDTH-1:0]  alt_tap,
  input logic [WIDTH-1:0]  dir_q,
  input logic [WIDTH-1:0]  out_q,
  input logic [WIDTH-1:0]  sfen_q
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (dir_q == '0 && out_q == '0 && sfen_q == SFEN_RESET));

  // R11
  oe_follows_regs_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pad_oe == $past((sfen_q & sf_oe_in) | (~sfen_q & dir_q)));

  // R5
  no_pull_while_driven_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & pad_pu) == '0);

  // R8
  no_pull_on_override_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pad_pu & $past(sfen_q)) == '0);

  // R9
  tap_delay_chk: assert property (@(posedge clk) disable iff (rst)
    alt_tap == $past(pad_in, 2));

  // R7
  pins_readonly_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(REG_PINS)) |=>
      ($stable(dir_q) && $stable(out_q) && $stable(sfen_q)));
endmodule

bind gpio_port_ctrl gpio_port_chk #(.WIDTH(WIDTH), .SFEN_RESET(SFEN_RESET)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .pad_in   (pad_in),
  .pad_oe   (pad_oe),
  .pad_pu   (pad_pu),
  .sf_oe_in (sf_oe_in),
  .alt_tap  (alt_tap),
  .dir_q    (dir_q),
  .out_q    (out_q),
  .sfen_q   (sfen_q)
);

// File: tb/test_gpio_port_ctrl.sv
module test_gpio_port_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_bit_en = 1'b0;
  logic [2:0] bus_bit_sel = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_oe, pad_out, pad_pu;
  logic [7:0] sf_oe_in = 8'hFF;
  logic [7:0] sf_out_in = '0;
  logic [7:0] alt_tap;
  int checks = 0;
  int errors = 0;
  logic [7:0] rd;

  always #10 clk = ~clk;

  gpio_port_ctrl i_gpio_port_ctrl (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_bit_en(bus_bit_en), .bus_bit_sel(bus_bit_sel), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pu(pad_pu), .sf_oe_in(sf_oe_in), .sf_out_in(sf_out_in), .alt_tap(alt_tap)
  );

  // fields: dir, out, sfen, sf_oe, sf_out, exp_oe, exp_out, exp_pu
  localparam logic [63:0] VEC [6] = '{
    64'h00_00_00_00_00_00_00_00,
    64'h00_FF_00_00_00_00_00_FF,
    64'hFF_A5_00_00_00_FF_A5_00,
    64'h0F_3C_00_00_00_0F_0C_30,
    64'hF0_55_81_01_81_71_51_04,
    64'hAA_CC_FF_33_0F_33_03_00
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic be, input logic [2:0] s);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_bit_en = be; bus_bit_sel = s;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; bus_bit_en = 1'b0;
  endtask

  task automatic rdreg(input logic [1:0] a, input logic be, input logic [2:0] s, output logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a; bus_bit_en = be; bus_bit_sel = s;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
    bus_bit_en = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 rdata in reset", bus_rdata, 8'h00);
    rst = 1'b0;
    settle();
    settle();
    chk("R1 debug override oe", pad_oe, 8'hF0);
    chk("R1 pullup off", pad_pu, 8'h00);
    chk("R1 out zero", pad_out, 8'h00);
    rdreg(2'd0, 1'b0, 3'd0, rd); chk("R1 dir reset", rd, 8'h00);
    rdreg(2'd1, 1'b0, 3'd0, rd); chk("R1 out reset", rd, 8'h00);
    rdreg(2'd3, 1'b0, 3'd0, rd); chk("R1 sfen reset", rd, 8'hF0);
    sf_oe_in = '0;

    // table: R4 R5 R6 R8 mixed patterns
    foreach (VEC[k]) begin
      sf_oe_in  = VEC[k][39:32];
      sf_out_in = VEC[k][31:24];
      wr(2'd0, VEC[k][63:56], 1'b0, 3'd0);
      wr(2'd1, VEC[k][55:48], 1'b0, 3'd0);
      wr(2'd3, VEC[k][47:40], 1'b0, 3'd0);
      settle();
      chk("R4/R5/R6/R8 pad_oe", pad_oe, VEC[k][23:16]);
      chk("R4/R6/R8 pad_out", pad_out, VEC[k][15:8]);
      chk("R5/R8 pad_pu", pad_pu, VEC[k][7:0]);
    end
    rdreg(2'd0, 1'b0, 3'd0, rd); chk("R2 dir readback", rd, 8'hAA);
    rdreg(2'd1, 1'b0, 3'd0, rd); chk("R2 out readback", rd, 8'hCC);

    // R3 single-bit access
    wr(2'd3, 8'h00, 1'b0, 3'd0);
    wr(2'd0, 8'h00, 1'b0, 3'd0);
    wr(2'd0, 8'h01, 1'b1, 3'd5);
    rdreg(2'd0, 1'b0, 3'd0, rd); chk("R3 bit set", rd, 8'h20);
    rdreg(2'd0, 1'b1, 3'd5, rd); chk("R3 bit read set", rd, 8'h01);
    rdreg(2'd0, 1'b1, 3'd4, rd); chk("R3 bit read clear", rd, 8'h00);
    wr(2'd0, 8'hFE, 1'b1, 3'd5);
    rdreg(2'd0, 1'b0, 3'd0, rd); chk("R3 bit clear uses wdata0", rd, 8'h00);

    // R10 open drain on pin 2
    wr(2'd1, 8'h00, 1'b0, 3'd0);
    wr(2'd0, 8'h01, 1'b1, 3'd2);
    settle();
    chk("R10 drive low oe", pad_oe, 8'h04);
    chk("R10 drive low out", pad_out, 8'h00);
    wr(2'd0, 8'h00, 1'b1, 3'd2);
    settle();
    chk("R10 release oe", pad_oe, 8'h00);
    chk("R10 release pu", pad_pu, 8'h00);

    // R11 registered pad timing
    wr(2'd0, 8'h11, 1'b0, 3'd0);
    chk("R11 pad old right after write", pad_oe, 8'h00);
    settle();
    chk("R11 pad new one edge later", pad_oe, 8'h11);

    // R7 pin register with outputs set, write ignored
    wr(2'd0, 8'hFF, 1'b0, 3'd0);
    pad_in = 8'h5A;
    settle(); settle();
    rdreg(2'd2, 1'b0, 3'd0, rd); chk("R7 pins with dir=1", rd, 8'h5A);
    wr(2'd2, 8'hFF, 1'b0, 3'd0);
    rdreg(2'd2, 1'b0, 3'd0, rd); chk("R7 pins after write", rd, 8'h5A);
    rdreg(2'd0, 1'b0, 3'd0, rd); chk("R7 dir untouched", rd, 8'hFF);
    rdreg(2'd2, 1'b1, 3'd1, rd); chk("R3 R7 bit read of pin", rd, 8'h01);

    // R9 tap latency
    @(negedge clk);
    pad_in = 8'hC3;
    @(posedge clk); @(negedge clk);
    chk("R9 tap after one edge", alt_tap, 8'h5A);
    @(posedge clk); @(negedge clk);
    chk("R9 tap after two edges", alt_tap, 8'hC3);
    wr(2'd0, 8'h00, 1'b0, 3'd0);
    settle();
    chk("R9 tap unaffected by drive", alt_tap, 8'hC3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule